// File: doc/BRIEF.md
# Lens Stepper Sequence Controller

This block drives the two coils of a small lens stepper through a complete positioning run in response to a single register write. A run applies holding current at the present electrical phase, steps a programmed number of times in the chosen direction, holds the new phase for the same length of time, and then switches both coils off. Two kinds of run are available. A target move steps quickly. A home run steps slowly and uses longer hold pulses.

The block receives two configuration bytes (a control byte and a setup byte), a write strobe for the control byte, and a 1 ms tick. It produces one enable bit and one level bit for each of the four coil pins, and a busy flag. Coil A sits on pins 0 and 1. Coil B sits on pins 2 and 3. Run parameters are captured when the run is accepted, and the electrical phase index is kept from one run to the next.

Top module: `lensStepSeq`

## Requirements
- R1: After reset, busyO is 0 and every drvEnO bit is 0. The next accepted run starts at phase 0, which drives pin0 high, pin1 low, pin2 high and pin3 low.
- R2: A startI pulse while idle with control bit 1 set raises busyO on the following cycle. With control bit 1 clear, no run starts and the coils stay off.
- R3: The step count is 2×(N+1), where N is control bits 7:3. Setup bit 5 set adds 64 more steps, for a range of 2 to 128.
- R4: Phases run in index order 0..7: A+B+, B+, A−B+, A−, A−B−, B−, A+B−, A+. Setup bit 3 = 1 (half step) moves the index by 1 per step; bit 3 = 0 (full step) moves it by 2. Control bit 0 = 0 walks the index upward, and 1 walks it downward, modulo 8.
- R5: Setup bits 2:0 select a hold pulse count of 1, 2, 4, 5, 8, 16, 32 or 1 for codes 0 to 7. The hold before stepping and the hold after stepping each last that count times a unit. The unit in ticks is 2 (move, full), 1 (move, half), 10 (home, full) or 5 (home, half).
- R6: Setup bit 4 selects a home run, with one step every 10 ticks. Otherwise a move runs, with one step every 2 ticks. A whole run therefore lasts 2×hold + steps×interval ticks.
- R7: When the final hold ends, busyO clears and all drvEnO bits go to 0 in the same cycle. Whenever busyO is 0, the coils are off.
- R8: The phase index is kept between runs. A write accepted while idle with control bit 2 = 0 returns the index to 0.
- R9: A startI pulse while busyO is 1 is ignored. It changes neither the run length, nor the final phase, nor the index.
- R10: An energised coil drives both of its pins (enable = 1). Positive polarity puts the lower pin high. A coil with no current has both enables and both levels at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickI | input | 1 | One-cycle pulse every millisecond |
| startI | input | 1 | Strobe marking a write of the control byte |
| ctrlRegI | input | 8 | Control byte: step field, counter reset, enable, direction |
| cfgRegI | input | 8 | Setup byte: extension, home, excitation, hold code |
| drvEnO | output | 4 | Per-pin drive enable (0 = high impedance) |
| drvHighO | output | 4 | Per-pin drive level when enabled |
| busyO | output | 1 | A run is in progress |

## Verification
The bench builds the block with its default step intervals of 2 and 10 ticks. It strobes tickI on every second clock, so the longest home run (128 steps with 32 hold pulses on each side) completes in a few thousand cycles. That puts the +64 extension, the largest hold code and both excitation modes in both directions within reach of both directed and seeded random runs. Run length, first phase and last phase are predicted from the field decodes alone. This includes runs that carry an intruding write and runs that follow a counter reset.

// File: rtl/lens_seq_pkg.sv
package lens_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD_PRE,
    ST_STEP,
    ST_HOLD_POST
  } seqState_e;

  // Strobes from control to the phase datapath
  typedef struct packed {
    logic clearIdx;
    logic energize;
    logic deenergize;
    logic advance;
    logic ccw;
    logic halfStep;
  } dpCmd_t;

  function automatic logic [5:0] holdPulses(input logic [2:0] code);
    case (code)
      3'd0: holdPulses = 6'd1;
      3'd1: holdPulses = 6'd2;
      3'd2: holdPulses = 6'd4;
      3'd3: holdPulses = 6'd5;
      3'd4: holdPulses = 6'd8;
      3'd5: holdPulses = 6'd16;
      3'd6: holdPulses = 6'd32;
      default: holdPulses = 6'd1;
    endcase
  endfunction

endpackage

// File: rtl/lensSeqCtrl.sv
module lensSeqCtrl
  import lens_seq_pkg::*;
#(
  parameter int MOVE_STEP_TICKS = 2,
  parameter int HOME_STEP_TICKS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickI,
  input  logic       startI,
  input  logic [7:0] ctrlRegI,
  input  logic [7:0] cfgRegI,
  output dpCmd_t     cmdO,
  output logic       busyO
);

  localparam int MAX_TICKS  = 32 * ((HOME_STEP_TICKS > MOVE_STEP_TICKS) ? HOME_STEP_TICKS : MOVE_STEP_TICKS);
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);
  localparam int STEP_W     = 8;
  localparam int MOVE_HALF  = (MOVE_STEP_TICKS / 2 > 0) ? MOVE_STEP_TICKS / 2 : 1;
  localparam int HOME_HALF  = (HOME_STEP_TICKS / 2 > 0) ? HOME_STEP_TICKS / 2 : 1;

  seqState_e          state;
  logic [CNT_W-1:0]   cnt, holdLen, stepLen;
  logic [STEP_W-1:0]  stepsLeft;
  logic               ccwQ, halfQ;

  logic               accept, launch, lastTick;
  logic [CNT_W-1:0]   unitTicks, holdTicks, intervalTicks;
  logic [STEP_W-1:0]  stepTotal;

  always_comb begin
    accept   = startI && (state == ST_IDLE);
    launch   = accept && ctrlRegI[1];
    lastTick = tickI && (cnt == CNT_W'(1));

    if (cfgRegI[4]) unitTicks = cfgRegI[3] ? CNT_W'(HOME_HALF) : CNT_W'(HOME_STEP_TICKS);
    else            unitTicks = cfgRegI[3] ? CNT_W'(MOVE_HALF) : CNT_W'(MOVE_STEP_TICKS);
    holdTicks     = CNT_W'(CNT_W'(holdPulses(cfgRegI[2:0])) * unitTicks);
    intervalTicks = cfgRegI[4] ? CNT_W'(HOME_STEP_TICKS) : CNT_W'(MOVE_STEP_TICKS);
    stepTotal     = {2'b00, ctrlRegI[7:3], 1'b0} + STEP_W'(2)
                  + (cfgRegI[5] ? STEP_W'(64) : STEP_W'(0));

    cmdO.clearIdx   = accept && !ctrlRegI[2];
    cmdO.energize   = launch;
    cmdO.advance    = (state == ST_STEP) && lastTick;
    cmdO.deenergize = (state == ST_HOLD_POST) && lastTick;
    cmdO.ccw        = ccwQ;
    cmdO.halfStep   = halfQ;
  end

  assign busyO = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      holdLen   <= '0;
      stepLen   <= '0;
      stepsLeft <= '0;
      ccwQ      <= 1'b0;
      halfQ     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          state     <= ST_HOLD_PRE;
          cnt       <= holdTicks;
          holdLen   <= holdTicks;
          stepLen   <= intervalTicks;
          stepsLeft <= stepTotal;
          ccwQ      <= ctrlRegI[0];
          halfQ     <= cfgRegI[3];
        end
        ST_HOLD_PRE: begin
          if (lastTick) begin
            state <= ST_STEP;
            cnt   <= stepLen;
          end else if (tickI) cnt <= cnt - 1'b1;
        end
        ST_STEP: begin
          if (lastTick) begin
            stepsLeft <= stepsLeft - 1'b1;
            if (stepsLeft == STEP_W'(1)) begin
              state <= ST_HOLD_POST;
              cnt   <= holdLen;
            end else cnt <= stepLen;
          end else if (tickI) cnt <= cnt - 1'b1;
        end
        default: begin
          if (lastTick) state <= ST_IDLE;
          else if (tickI) cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // R2: an accepted enabled write makes the block busy next cycle
  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startI && !busyO && ctrlRegI[1]) |=> busyO);

  // R3: stepping never runs with an exhausted step budget
  p_steps_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STEP) |-> (stepsLeft != '0));

  // R9: a write during a run leaves captured timing untouched
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && startI) |=> ((stepLen == $past(stepLen)) && (holdLen == $past(holdLen))));

  // R7: at most one datapath action per cycle
  p_single_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdO.energize, cmdO.deenergize, cmdO.advance}));

endmodule

// File: rtl/lensPhaseDp.sv
module lensPhaseDp
  import lens_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmdI,
  output logic [3:0] drvEnO,
  output logic [3:0] drvHighO
);

  localparam int IDX_W = 3;

  logic [IDX_W-1:0] idxQ, stepMag;
  logic             activeQ;
  logic [1:0]       polA, polB; // 01 = positive, 10 = negative, 00 = off

  assign stepMag = cmdI.halfStep ? IDX_W'(1) : IDX_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ    <= '0;
      activeQ <= 1'b0;
    end else begin
      if (cmdI.clearIdx)     idxQ <= '0;
      else if (cmdI.advance) idxQ <= cmdI.ccw ? idxQ - stepMag : idxQ + stepMag;
      if (cmdI.energize)        activeQ <= 1'b1;
      else if (cmdI.deenergize) activeQ <= 1'b0;
    end
  end

  always_comb begin
    case (idxQ)
      3'd0, 3'd6, 3'd7: polA = 2'b01;
      3'd2, 3'd3, 3'd4: polA = 2'b10;
      default:          polA = 2'b00;
    endcase
    case (idxQ)
      3'd0, 3'd1, 3'd2: polB = 2'b01;
      3'd4, 3'd5, 3'd6: polB = 2'b10;
      default:          polB = 2'b00;
    endcase
    if (!activeQ) begin
      polA = 2'b00;
      polB = 2'b00;
    end
    drvEnO   = {{2{|polB}}, {2{|polA}}};
    drvHighO = {polB[1], polB[0], polA[1], polA[0]};
  end

  // R8: the index moves only on an advance or a clear strobe
  p_index_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdI.advance && !cmdI.clearIdx) |=> (idxQ == $past(idxQ)));

  // R4: full steps preserve index parity
  p_full_parity_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdI.advance && !cmdI.halfStep && !cmdI.clearIdx) |=> (idxQ[0] == $past(idxQ[0])));

  // R10: a driven pin pair never has both levels high
  p_pair_polarity_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(drvHighO[0] && drvHighO[1]) && !(drvHighO[2] && drvHighO[3]));

endmodule

// File: rtl/lensStepSeq.sv
module lensStepSeq
  import lens_seq_pkg::*;
#(
  parameter int MOVE_STEP_TICKS = 2,
  parameter int HOME_STEP_TICKS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickI,
  input  logic       startI,
  input  logic [7:0] ctrlRegI,
  input  logic [7:0] cfgRegI,
  output logic [3:0] drvEnO,
  output logic [3:0] drvHighO,
  output logic       busyO
);

  dpCmd_t cmd;

  lensSeqCtrl #(
    .MOVE_STEP_TICKS(MOVE_STEP_TICKS),
    .HOME_STEP_TICKS(HOME_STEP_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickI(tickI), .startI(startI),
    .ctrlRegI(ctrlRegI), .cfgRegI(cfgRegI), .cmdO(cmd), .busyO(busyO)
  );

  lensPhaseDp u_dp (
    .clk(clk), .rstN(rstN), .cmdI(cmd), .drvEnO(drvEnO), .drvHighO(drvHighO)
  );

  // R7: coils are released whenever no run is in progress
  p_idle_coils_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busyO |-> (drvEnO == 4'b0000));

endmodule

// File: tb/lensStepSeq_tb.sv
module lensStepSeq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickI = 1'b0;
  logic       startI = 1'b0;
  logic [7:0] ctrlRegI = '0;
  logic [7:0] cfgRegI = '0;
  logic [3:0] drvEnO, drvHighO;
  logic       busyO;

  int tests = 0;
  int fails = 0;
  int expIdx = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lensStepSeq u_dut (
    .clk(clk), .rstN(rstN), .tickI(tickI), .startI(startI),
    .ctrlRegI(ctrlRegI), .cfgRegI(cfgRegI),
    .drvEnO(drvEnO), .drvHighO(drvHighO), .busyO(busyO)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {en[3:0], high[3:0]} for a phase index
  function automatic logic [7:0] pinsFor(input int idx);
    logic [3:0] en, hi;
    int i = ((idx % 8) + 8) % 8;
    en = 4'b0; hi = 4'b0;
    if (i == 0 || i == 6 || i == 7) begin en[1:0] = 2'b11; hi[0] = 1'b1; end
    if (i == 2 || i == 3 || i == 4) begin en[1:0] = 2'b11; hi[1] = 1'b1; end
    if (i == 0 || i == 1 || i == 2) begin en[3:2] = 2'b11; hi[2] = 1'b1; end
    if (i == 4 || i == 5 || i == 6) begin en[3:2] = 2'b11; hi[3] = 1'b1; end
    return {en, hi};
  endfunction

  function automatic int expSteps(input logic [7:0] c, input logic [7:0] g);
    return 2 * (int'(c[7:3]) + 1) + (g[5] ? 64 : 0);
  endfunction

  function automatic int expHold(input logic [7:0] g);
    int p, u;
    case (g[2:0])
      3'd0: p = 1; 3'd1: p = 2; 3'd2: p = 4; 3'd3: p = 5;
      3'd4: p = 8; 3'd5: p = 16; 3'd6: p = 32; default: p = 1;
    endcase
    if (g[4]) u = g[3] ? 5 : 10;
    else      u = g[3] ? 1 : 2;
    return p * u;
  endfunction

  task automatic writeCtrl(input logic [7:0] c, input logic [7:0] g);
    @(negedge clk);
    ctrlRegI = c; cfgRegI = g; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk); tickI = 1'b1;
    @(negedge clk); tickI = 1'b0;
  endtask

  // Runs a sequence; intrude = send a conflicting write mid-run (R9)
  task automatic runSeq(input logic [7:0] c, input logic [7:0] g, input bit intrude);
    int total, n, moves;
    logic [7:0] last;
    if (!c[2]) expIdx = 0;
    writeCtrl(c, g);
    check("R2 busy after write", busyO, c[1]);
    if (!c[1]) begin
      check("R2 coils off when disabled", drvEnO, 0);
      return;
    end
    check("R1/R10 first phase pins", {drvEnO, drvHighO}, pinsFor(expIdx));
    total = 2 * expHold(g) + expSteps(c, g) * (g[4] ? 10 : 2);
    n = 0;
    last = {drvEnO, drvHighO};
    while (busyO && n < 5000) begin
      if (intrude && n == 3) writeCtrl(8'b11111010 ^ c, 8'h2E);
      last = {drvEnO, drvHighO};
      tickOnce();
      n++;
    end
    check("R5/R6/R3 run length in ticks", n, total);
    moves = expSteps(c, g) * (g[3] ? 1 : 2) * (c[0] ? -1 : 1);
    expIdx = (((expIdx + moves) % 8) + 8) % 8;
    check("R4 final phase pins", last, pinsFor(expIdx));
    check("R7 busy cleared", busyO, 0);
    check("R7 coils off after run", drvEnO, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busyO, 0);
    check("R1 coils off after reset", drvEnO, 0);

    // R2: disabled write does not start
    runSeq(8'b00000100, 8'h00, 0);
    // R1/R3: 2 steps, full, move, shortest hold, from initial phase
    runSeq(8'b00000110, 8'h00, 0);
    // R4/R8: half step downward, 8 steps, code 3, index kept
    runSeq(8'b00011111, 8'b00001011, 0);
    // R3/R6/R5: home, full, +64, 32 pulses: 128 steps
    runSeq(8'b11111110, 8'b00110110, 0);
    // R9: intruding write while busy
    runSeq(8'b00101111, 8'b00001101, 1);
    // R8: reset-only write, then run from phase 0
    runSeq(8'b00000000, 8'h00, 0);
    runSeq(8'b00000110, 8'b00011111, 0);
    // R5: code 7 maps to a single pulse, half step move
    runSeq(8'b00010111, 8'b00001111, 0);

    for (int k = 0; k < 14; k++) begin
      logic [7:0] c, g;
      c = 8'($urandom);
      c[1] = 1'b1;
      g = 8'($urandom) & 8'h3F;
      if (k % 4 != 0) g[4] = 1'b0;
      runSeq(c, g, (k % 5) == 2);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule